// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Unit

This block is the interrupt front end of an 8-bit processor core. It watches five request pins: a trap that cannot be masked, three maskable restart sources and one general request line. It holds a global enable flag and one mask bit per maskable source. It keeps a sticky latch for the single edge-triggered source and picks the winning request by a fixed priority. It then presents the core with one request, an internal vector address, and a flag that marks whether the core must instead run an external acknowledge cycle.

In this document the three maskable sources are named M2, M1 and M0, from highest to lowest rank. M2 is edge-triggered and latched. M1 and M0 follow their pin levels. The core reaches the unit through single-cycle strobes for enable, disable, mask-write, status-read and acknowledge.

The mask-write byte can change the mask bits, clear the M2 latch and drive the serial output pin. Each of these actions is selected on its own. The status read returns a byte that shows the serial input pin, the pending sources, the global enable flag and the masks. Both operations occupy four clock cycles.

Top module: `pirq_unit`

## Requirements
- R1: A high `trap_in` sampled on one rising edge raises `irq_req` after that edge with `irq_vec` = 0x24 and `irq_ext` = 0. This holds whatever the enable flag and the masks are, so the trap always serves as a wake request.
- R2: Priority, highest first, is trap, M2, M1, M0, general request. The vectors are 0x3C for M2, 0x34 for M1 and 0x2C for M0.
- R3: `en_stb` sets the global enable flag and `dis_stb` clears it. If both strobes arrive in the same cycle, disable wins. While the flag is 0, only the trap can raise `irq_req`.
- R4: An enabled general request raises `irq_req` with `irq_ext` = 1 and `irq_vec` = 0x00.
- R5: On a mask-write with bit 3 set, bits 2, 1 and 0 become the masks of M2, M1 and M0 (1 = masked). With bit 3 clear, the masks keep their values.
- R6: After reset, all three masks are 1, the enable flag is 0, the M2 latch is 0 and `ser_out` is 0.
- R7: A rising edge on `mk_edge_in` sets the M2 latch, which stays set after the pin falls. M1 and M0 pending follow their pin levels. Pending bits do not depend on the masks.
- R8: A mask-write with bit 4 set clears the M2 latch without any request being served.
- R9: A mask-write with bit 6 set copies bit 7 to `ser_out`. With bit 6 clear, `ser_out` keeps its value.
- R10: The status byte is {ser_in, pend M2, pend M1, pend M0, enable, mask M2, mask M1, mask M0}, MSB first.
- R11: A mask-write or status-read strobe takes effect on the third rising edge after the edge that samples it. `op_busy` is high during those three cycles, and strobes that arrive while it is high are ignored.
- R12: `ack_stb` clears the enable flag. When the granted source is M2, it also clears the M2 latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_in | input | 1 | Non-maskable trap request |
| mk_edge_in | input | 1 | M2 request, edge-triggered |
| mk_hi_in | input | 1 | M1 request, level |
| mk_lo_in | input | 1 | M0 request, level |
| gen_in | input | 1 | General request, needs an external acknowledge |
| ser_in | input | 1 | Serial input bit, shown in the status byte |
| en_stb | input | 1 | Set the global enable flag |
| dis_stb | input | 1 | Clear the global enable flag |
| mw_stb | input | 1 | Start a mask-write |
| mw_data | input | 8 | Mask-write byte |
| sr_stb | input | 1 | Start a status read |
| ack_stb | input | 1 | The core accepts the current request |
| sr_data | output | 8 | Status byte from the last completed read |
| op_busy | output | 1 | A mask-write or status-read is in progress |
| ser_out | output | 1 | Serial output bit |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | 8 | Vector of the granted source |
| irq_ext | output | 1 | The granted source is the general request |

## Verification
Level pins reach `irq_req`, `irq_vec` and `irq_ext` one rising edge after they are sampled. The edge-triggered source needs two edges, because the edge is detected and then latched. Enable, disable and acknowledge act on the edge that samples them. A mask-write or status-read commits on the third edge after its strobe edge. The bench drives on falling edges, steps exactly that number of edges and samples on the following falling edge. It also checks the cycle just before a commit, to show that the old masks still apply there.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_M2   = 3'd2,
    SRC_M1   = 3'd3,
    SRC_M0   = 3'd4,
    SRC_GEN  = 3'd5
  } pirq_src_e;

  localparam int NSRC = 5;

  localparam logic [7:0] VEC_TRAP = 8'h24;
  localparam logic [7:0] VEC_M2   = 8'h3C;
  localparam logic [7:0] VEC_M1   = 8'h34;
  localparam logic [7:0] VEC_M0   = 8'h2C;
  localparam logic [7:0] VEC_NONE = 8'h00;

  // mask-write byte fields
  localparam int MW_MSE = 3;
  localparam int MW_CLR = 4;
  localparam int MW_SOE = 6;
  localparam int MW_SOD = 7;

  // rank 0 is the highest priority
  function automatic pirq_src_e f_rank(input int i);
    case (i)
      0:       return SRC_TRAP;
      1:       return SRC_M2;
      2:       return SRC_M1;
      3:       return SRC_M0;
      default: return SRC_GEN;
    endcase
  endfunction

  function automatic logic [7:0] f_vector(input pirq_src_e s);
    case (s)
      SRC_TRAP: return VEC_TRAP;
      SRC_M2:   return VEC_M2;
      SRC_M1:   return VEC_M1;
      SRC_M0:   return VEC_M0;
      default:  return VEC_NONE;
    endcase
  endfunction

  function automatic logic [7:0] f_status(input logic sin, input logic [2:0] pend,
                                          input logic ie, input logic [2:0] msk);
    return {sin, pend, ie, msk};
  endfunction
endpackage

// File: rtl/pirq_capture.sv
`timescale 1ns/1ps
module pirq_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_in,
  input  logic m2_in,
  input  logic m1_in,
  input  logic m0_in,
  input  logic gen_in,
  input  logic sin_in,
  input  logic m2_clr,
  output logic trap_q,
  output logic m2_pend,
  output logic m1_q,
  output logic m0_q,
  output logic gen_q,
  output logic sin_q
);
  logic m2_q, m2_d;
  logic m2_rise;

  assign m2_rise = m2_q & ~m2_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {trap_q, m2_q, m1_q, m0_q, gen_q, sin_q} <= '0;
      m2_d <= 1'b0;
    end else begin
      {trap_q, m2_q, m1_q, m0_q, gen_q, sin_q} <= {trap_in, m2_in, m1_in, m0_in, gen_in, sin_in};
      m2_d <= m2_q;
    end
  end

  // a new edge takes precedence over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       m2_pend <= 1'b0;
    else if (m2_rise) m2_pend <= 1'b1;
    else if (m2_clr)  m2_pend <= 1'b0;
  end

  a_r7_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    m2_rise |=> m2_pend);
  a_r8_clear_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (m2_clr && !m2_rise) |=> !m2_pend);
endmodule

// File: rtl/pirq_arbiter.sv
`timescale 1ns/1ps
module pirq_arbiter
  import pirq_pkg::*;
(
  input  logic       trap,
  input  logic       m2_pend,
  input  logic       m1_lvl,
  input  logic       m0_lvl,
  input  logic       gen_lvl,
  input  logic       ie,
  input  logic [2:0] mask,
  output pirq_src_e  grant,
  output logic       req,
  output logic [7:0] vec,
  output logic       ext
);
  logic [NSRC-1:0] elig;

  assign elig = {ie & gen_lvl,
                 ie & m0_lvl  & ~mask[0],
                 ie & m1_lvl  & ~mask[1],
                 ie & m2_pend & ~mask[2],
                 trap};

  always_comb begin
    grant = SRC_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) grant = f_rank(i);
    end
  end

  assign req = |elig;
  assign vec = f_vector(grant);
  assign ext = (grant == SRC_GEN);
endmodule

// File: rtl/pirq_ctl.sv
`timescale 1ns/1ps
module pirq_ctl
  import pirq_pkg::*;
#(
  parameter int OP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_stb,
  input  logic       dis_stb,
  input  logic       ack_stb,
  input  logic       mw_stb,
  input  logic [7:0] mw_data,
  input  logic       sr_stb,
  input  logic       sin_q,
  input  logic [2:0] pend,
  output logic       ie_q,
  output logic [2:0] mask_q,
  output logic       sod_q,
  output logic       m2_swclr,
  output logic [7:0] sr_data,
  output logic       busy
);
  localparam int CW = (OP_CYCLES > 2) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(OP_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          op_wr;
  logic [7:0]    op_byte;
  logic          start, commit, commit_wr, commit_rd;
  logic          unused_bit5;

  assign unused_bit5 = op_byte[5];
  assign busy      = (cnt != '0);
  assign start     = !busy && (mw_stb || sr_stb);
  assign commit    = busy && (cnt == LAST);
  assign commit_wr = commit && op_wr;
  assign commit_rd = commit && !op_wr;
  assign m2_swclr  = commit_wr && op_byte[MW_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      op_wr   <= 1'b0;
      op_byte <= '0;
    end else if (start) begin
      cnt     <= CW'(1);
      op_wr   <= mw_stb;
      op_byte <= mw_data;
    end else if (commit) begin
      cnt <= '0;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 3'b111;
      sod_q   <= 1'b0;
      sr_data <= '0;
    end else begin
      if (commit_wr && op_byte[MW_MSE]) mask_q <= op_byte[2:0];
      if (commit_wr && op_byte[MW_SOE]) sod_q  <= op_byte[MW_SOD];
      if (commit_rd) sr_data <= f_status(sin_q, pend, ie_q, mask_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ie_q <= 1'b0;
    else if (dis_stb || ack_stb) ie_q <= 1'b0;
    else if (en_stb)             ie_q <= 1'b1;
  end

  a_r3_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dis_stb |=> !ie_q);
  a_r12_ack_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> !ie_q);
  a_r11_masks_move_on_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_wr |=> $stable(mask_q));
  a_r11_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy);
endmodule

// File: rtl/pirq_unit.sv
`timescale 1ns/1ps
module pirq_unit
  import pirq_pkg::*;
#(
  parameter int OP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_in,
  input  logic       mk_edge_in,
  input  logic       mk_hi_in,
  input  logic       mk_lo_in,
  input  logic       gen_in,
  input  logic       ser_in,
  input  logic       en_stb,
  input  logic       dis_stb,
  input  logic       mw_stb,
  input  logic [7:0] mw_data,
  input  logic       sr_stb,
  input  logic       ack_stb,
  output logic [7:0] sr_data,
  output logic       op_busy,
  output logic       ser_out,
  output logic       irq_req,
  output logic [7:0] irq_vec,
  output logic       irq_ext
);
  logic       trap_q, m2_pend, m1_q, m0_q, gen_q, sin_q;
  logic       ie_q, m2_swclr, m2_clr;
  logic [2:0] mask_q;
  pirq_src_e  grant;

  assign m2_clr = m2_swclr || (ack_stb && grant == SRC_M2);

  pirq_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .trap_in(trap_in), .m2_in(mk_edge_in), .m1_in(mk_hi_in), .m0_in(mk_lo_in),
    .gen_in(gen_in), .sin_in(ser_in), .m2_clr(m2_clr),
    .trap_q(trap_q), .m2_pend(m2_pend), .m1_q(m1_q), .m0_q(m0_q),
    .gen_q(gen_q), .sin_q(sin_q)
  );

  pirq_ctl #(.OP_CYCLES(OP_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .en_stb(en_stb), .dis_stb(dis_stb), .ack_stb(ack_stb),
    .mw_stb(mw_stb), .mw_data(mw_data), .sr_stb(sr_stb),
    .sin_q(sin_q), .pend({m2_pend, m1_q, m0_q}),
    .ie_q(ie_q), .mask_q(mask_q), .sod_q(ser_out), .m2_swclr(m2_swclr),
    .sr_data(sr_data), .busy(op_busy)
  );

  pirq_arbiter u_arb (
    .trap(trap_q), .m2_pend(m2_pend), .m1_lvl(m1_q), .m0_lvl(m0_q), .gen_lvl(gen_q),
    .ie(ie_q), .mask(mask_q),
    .grant(grant), .req(irq_req), .vec(irq_vec), .ext(irq_ext)
  );

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_trap_unconditional: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(trap_in)) |-> (irq_req && irq_vec == VEC_TRAP && !irq_ext));
endmodule

// File: tb/pirq_unit_tb_top.sv
`timescale 1ns/1ps
module pirq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trap_in = 0, mk_edge_in = 0, mk_hi_in = 0, mk_lo_in = 0, gen_in = 0, ser_in = 0;
  logic       en_stb = 0, dis_stb = 0, mw_stb = 0, sr_stb = 0, ack_stb = 0;
  logic [7:0] mw_data = 8'h00;
  logic [7:0] sr_data, irq_vec;
  logic       op_busy, ser_out, irq_req, irq_ext;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pirq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .mk_edge_in(mk_edge_in),
    .mk_hi_in(mk_hi_in), .mk_lo_in(mk_lo_in), .gen_in(gen_in), .ser_in(ser_in),
    .en_stb(en_stb), .dis_stb(dis_stb), .mw_stb(mw_stb), .mw_data(mw_data),
    .sr_stb(sr_stb), .ack_stb(ack_stb), .sr_data(sr_data), .op_busy(op_busy),
    .ser_out(ser_out), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ext(irq_ext)
  );

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic mwrite(input logic [7:0] b);
    mw_stb = 1; mw_data = b; step; mw_stb = 0;
    repeat (3) step;
  endtask

  task automatic sread(output logic [7:0] b);
    sr_stb = 1; step; sr_stb = 0;
    repeat (3) step;
    b = sr_data;
  endtask

  task automatic set_ie(input logic v);
    en_stb = v; dis_stb = !v; step; en_stb = 0; dis_stb = 0;
  endtask

  // {req, ext, vec}
  function automatic logic [9:0] expect_out(input logic t, input logic p2, input logic l1,
                                            input logic l0, input logic g, input logic ie,
                                            input logic [2:0] m);
    if (t)                return {2'b10, 8'h24};
    if (ie && p2 && !m[2]) return {2'b10, 8'h3C};
    if (ie && l1 && !m[1]) return {2'b10, 8'h34};
    if (ie && l0 && !m[0]) return {2'b10, 8'h2C};
    if (ie && g)           return {2'b11, 8'h00};
    return 10'h000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    repeat (2) step;
    rst_n = 1;
    step;
    // R6 reset state
    check("R6 req", irq_req, 0);
    check("R6 ser_out", ser_out, 0);
    sread(st);
    check("R6/R10 status", st, 8'h07);

    // R1 latency and trap with everything masked
    trap_in = 1;
    check("R1 before edge", irq_req, 0);
    step;
    check("R1 trap", {irq_req, irq_ext, irq_vec}, {2'b10, 8'h24});
    trap_in = 0; step;
    check("R1 trap gone", irq_req, 0);

    // R7 latch persists
    mwrite(8'h08); set_ie(1);
    mk_edge_in = 1; step; mk_edge_in = 0; step;
    check("R7 M2 latched", {irq_req, irq_vec}, {1'b1, 8'h3C});
    repeat (3) step;
    check("R7 M2 held", {irq_req, irq_vec}, {1'b1, 8'h3C});

    // R12 ack clears enable and the M2 latch
    ack_stb = 1; step; ack_stb = 0;
    check("R12 ack disables", irq_req, 0);
    set_ie(1);
    check("R12 latch cleared by ack", irq_req, 0);

    // R8 software clear of the latch
    mk_edge_in = 1; step; mk_edge_in = 0; step;
    check("R8 M2 set again", {irq_req, irq_vec}, {1'b1, 8'h3C});
    mwrite(8'h10);
    check("R8 cleared", irq_req, 0);
    sread(st);
    check("R8/R10 status", st, 8'h08);

    // R5 bit3 clear keeps masks
    mwrite(8'h05);
    sread(st);
    check("R5 masks kept", st, 8'h08);

    // R3 disable wins over enable
    en_stb = 1; dis_stb = 1; step; en_stb = 0; dis_stb = 0;
    sread(st);
    check("R3 disable wins", st, 8'h00);

    // R9 serial out
    mwrite(8'hC0); check("R9 sod set", ser_out, 1);
    mwrite(8'h80); check("R9 sod kept", ser_out, 1);
    mwrite(8'h40); check("R9 sod cleared", ser_out, 0);

    // R11 timing and ignored strobe while busy
    set_ie(1);
    mk_hi_in = 1; step;
    check("R11 setup M1", {irq_req, irq_vec}, {1'b1, 8'h34});
    mw_stb = 1; mw_data = 8'h0F; step; mw_stb = 0;
    check("R11 busy", op_busy, 1);
    step; step;
    check("R11 old masks before commit", irq_req, 1);
    step;
    check("R11 commit", {irq_req, op_busy}, 2'b00);
    sr_stb = 1; step; sr_stb = 0;
    mw_stb = 1; mw_data = 8'h08; step; mw_stb = 0;
    step; step;
    check("R11/R10 status", sr_data, 8'h2F);
    repeat (4) step;
    check("R11 write ignored", {irq_req, op_busy}, 2'b00);

    // R12 level source returns after re-enable
    mwrite(8'h08);
    check("R12 M1 present", {irq_req, irq_vec}, {1'b1, 8'h34});
    ack_stb = 1; step; ack_stb = 0;
    check("R12 ack M1", irq_req, 0);
    set_ie(1);
    check("R12 M1 back", {irq_req, irq_vec}, {1'b1, 8'h34});
    mk_hi_in = 0; step;
    check("R7 level follows", irq_req, 0);

    // R4 general request
    gen_in = 1; step;
    check("R4 general", {irq_req, irq_ext, irq_vec}, {2'b11, 8'h00});
    set_ie(0);
    check("R4 gated", irq_req, 0);
    gen_in = 0;

    // R2 R3 R7 R10 sweep
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int p = 0; p < 32; p++) begin
          logic [9:0] ex;
          {trap_in, mk_edge_in, mk_hi_in, mk_lo_in, gen_in} = 5'b0;
          ser_in = 0;
          mwrite(8'h18 | 8'(m));
          set_ie(e[0]);
          {trap_in, mk_edge_in, mk_hi_in, mk_lo_in, gen_in} = 5'(p);
          ser_in = p[0] ^ m[0];
          step; step;
          ex = expect_out(p[4], p[3], p[2], p[1], p[0], e[0], 3'(m));
          check("R2 sweep out", {irq_req, irq_ext, irq_vec}, ex);
          sread(st);
          check("R10 sweep status", st, {p[0] ^ m[0], p[3], p[2], p[1], e[0], 3'(m)});
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule